// File: doc/BRIEF.md
# Processor Duty-Cycle Throttle Controller

This block lowers a processor's average activity by driving a suspend line on and off in a repeating pattern. Software programs four things: a 4-bit throttle value, an enable bit, a start-delay count and a time-slice scale factor. Once the enable is set, the block waits out the start delay. It then alternates a suspend phase of (15 − value) slices with a run phase of value slices, where each slice lasts scale-factor clock cycles. Interrupt-class inputs pause the pattern. The pattern then continues from the point where it stopped. A non-maskable interrupt or a sleep entry turns throttling off.

A second path gives a one-shot full suspend. A side-effecting read of the level-2 port with byte lane 0 active returns zero and arms a request. After the same start delay, the suspend line is held until a wake event arrives. An abort input cancels the request while the delay is still running. Clock gating, interrupt generation and address decoding belong to neighbouring logic.

Top module: `throttle_ctl`

## Requirements
- R1: After reset the control register reads 0x0000000F (value 15, enable clear), the delay and scale registers read 0, and `suspend` is low.
- R2: Register addresses are 0 control, 1 level-2 port, 2 start delay, 3 scale. In the control register, bits 3:0 hold the throttle value and bit 4 holds the enable. All bits above 4 are stored and read back as written.
- R3: With value v in 1..14, scale K ≥ 1 and delay D, `suspend` first rises D+1 cycles after the clock edge that captures the enabling write. It then stays high for (15−v)·K cycles and low for v·K cycles, and this repeats.
- R4: A write to the control register while the enable is set leaves bits 3:0 unchanged but updates the other bits.
- R5: A value of 15, a value of 0 or a scale of 0 never asserts `suspend` through throttling.
- R6: `nmi` or `sleep` at a clock edge clears the enable. From the next cycle `suspend` is low and the control register reads bit 4 as 0.
- R7: While `irq`, `smi` or `dbg_int` is high, the throttle pattern drives `suspend` low in that same cycle and its timing is frozen. When the input drops, the pattern resumes where it stopped.
- R8: A read of address 1 with `rd_io` high and `rd_be[0]` high returns 0 and requests a full suspend. `suspend` is high from D cycles after the capturing edge and stays high until an edge sees `irq`, `smi`, `dbg_int` or `nmi`.
- R9: `abort` high at any edge while a level-2 request is still counting its delay cancels it, and `suspend` stays low.
- R10: A read of address 1 with `rd_io` low, or with `rd_be[0]` low, returns 0 and has no effect on `suspend`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read address |
| rd_io | input | 1 | Read comes over the side-effecting port path |
| rd_be | input | 4 | Byte lanes of the read |
| rd_data | output | 32 | Read data (combinational) |
| irq | input | 1 | Maskable interrupt active |
| smi | input | 1 | System management interrupt active |
| dbg_int | input | 1 | Debug interrupt active |
| nmi | input | 1 | Non-maskable interrupt |
| sleep | input | 1 | System sleep entry |
| abort | input | 1 | Cancel a pending level-2 suspend |
| suspend | output | 1 | Processor suspend request |

## Verification
The assertions assume that the throttle value is changed only through the register path. They also assume that the interrupt, abort and sleep inputs are synchronous to the block clock and are driven between edges. The bench drives every input at the falling edge and holds it across the next rising edge. It keeps the scale and delay registers small, so every phase boundary falls inside a short run and can be compared with the arithmetic model cycle by cycle. Pause pulses are placed only while throttling is enabled. Level-2 requests are issued only when throttling is off, so the two suspend sources are checked one at a time.

// File: rtl/thr_pkg.sv
package thr_pkg;
  localparam int VAL_W = 4;

  typedef enum logic [1:0] {
    A_CTRL  = 2'd0,
    A_LVL2  = 2'd1,
    A_DELAY = 2'd2,
    A_SCALE = 2'd3
  } addr_e;

  typedef enum logic [1:0] {
    T_IDLE,
    T_WAIT,
    T_SUSP,
    T_RUN
  } thr_st_e;

  typedef enum logic [1:0] {
    L_IDLE,
    L_WAIT,
    L_HOLD
  } l2_st_e;
endpackage

// File: rtl/thr_regs.sv
module thr_regs
  import thr_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DLY_W = 16,
  parameter int SCL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  input  logic [1:0]       rd_addr,
  input  logic             nmi,
  input  logic             sleep,
  output logic [DW-1:0]    rd_data,
  output logic             en,
  output logic [VAL_W-1:0] val,
  output logic [DLY_W-1:0] delay,
  output logic [SCL_W-1:0] scale
);
  localparam int               EN_BIT   = VAL_W;
  localparam logic [DW-1:0]    CTRL_RST = DW'(15);

  logic [DW-1:0]    ctrl_q, ctrl_d;
  logic [DLY_W-1:0] dly_q, dly_d;
  logic [SCL_W-1:0] scl_q, scl_d;
  logic             wr_ctrl, wr_dly, wr_scl;

  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_dly  = wr_en && (wr_addr == A_DELAY);
  assign wr_scl  = wr_en && (wr_addr == A_SCALE);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d[DW-1:EN_BIT] = wr_data[DW-1:EN_BIT];
      if (!ctrl_q[EN_BIT]) ctrl_d[VAL_W-1:0] = wr_data[VAL_W-1:0];
    end
    if (nmi || sleep) ctrl_d[EN_BIT] = 1'b0;
  end

  always_comb begin
    dly_d = wr_dly ? wr_data[DLY_W-1:0] : dly_q;
    scl_d = wr_scl ? wr_data[SCL_W-1:0] : scl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      dly_q  <= '0;
      scl_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      dly_q  <= dly_d;
      scl_q  <= scl_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (rd_addr)
        A_CTRL:  rd_data = ctrl_q;
        A_DELAY: rd_data = DW'(dly_q);
        A_SCALE: rd_data = DW'(scl_q);
        default: rd_data = '0;
      endcase
    end
  end

  assign en    = ctrl_q[EN_BIT];
  assign val   = ctrl_q[VAL_W-1:0];
  assign delay = dly_q;
  assign scale = scl_q;

  a_r4_value_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && en) |=> $stable(val));
  a_r6_force_off: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi || sleep) |=> !en);
endmodule

// File: rtl/thr_seq.sv
module thr_seq
  import thr_pkg::*;
#(
  parameter int DLY_W = 16,
  parameter int SCL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [VAL_W-1:0] val,
  input  logic [DLY_W-1:0] delay,
  input  logic [SCL_W-1:0] scale,
  input  logic             pause,
  output logic             susp
);
  localparam int PW = VAL_W + SCL_W;

  thr_st_e          st_q, st_d;
  logic [DLY_W-1:0] dcnt_q, dcnt_d;
  logic [PW-1:0]    pcnt_q, pcnt_d;

  logic [VAL_W-1:0] v_eff, s_sl;
  logic [PW-1:0]    s_len, r_len;
  logic             no_susp;
  thr_st_e          st_go;
  logic [PW-1:0]    pcnt_go;

  always_comb begin
    v_eff   = (val == '0) ? '1 : val;
    s_sl    = VAL_W'(15) - v_eff;
    s_len   = PW'(s_sl) * PW'(scale);
    r_len   = PW'(v_eff) * PW'(scale);
    no_susp = (s_len == '0);
    st_go   = no_susp ? T_RUN : T_SUSP;
    pcnt_go = no_susp ? '0 : s_len - PW'(1);
  end

  always_comb begin
    st_d   = st_q;
    dcnt_d = dcnt_q;
    pcnt_d = pcnt_q;
    if (!en) begin
      st_d = T_IDLE;
    end else if (!pause) begin
      case (st_q)
        T_IDLE: begin
          if (delay == '0) begin
            st_d   = st_go;
            pcnt_d = pcnt_go;
          end else begin
            st_d   = T_WAIT;
            dcnt_d = delay - DLY_W'(1);
          end
        end
        T_WAIT: begin
          if (dcnt_q == '0) begin
            st_d   = st_go;
            pcnt_d = pcnt_go;
          end else begin
            dcnt_d = dcnt_q - DLY_W'(1);
          end
        end
        T_SUSP: begin
          if (pcnt_q == '0) begin
            st_d   = T_RUN;
            pcnt_d = (r_len == '0) ? '0 : r_len - PW'(1);
          end else begin
            pcnt_d = pcnt_q - PW'(1);
          end
        end
        default: begin
          if (pcnt_q == '0) begin
            st_d   = st_go;
            pcnt_d = pcnt_go;
          end else begin
            pcnt_d = pcnt_q - PW'(1);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= T_IDLE;
      dcnt_q <= '0;
      pcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      dcnt_q <= dcnt_d;
      pcnt_q <= pcnt_d;
    end
  end

  assign susp = (st_q == T_SUSP) && en && !pause;

  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (pause && en) |=> (st_q == $past(st_q) && pcnt_q == $past(pcnt_q) && dcnt_q == $past(dcnt_q)));
  a_r5_legal_value: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == T_SUSP) |-> (val != '0 && val != '1));
  a_r6_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (st_q == T_IDLE));
endmodule

// File: rtl/lvl2_ctl.sv
module lvl2_ctl
  import thr_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             abort,
  input  logic             wake,
  input  logic [DLY_W-1:0] delay,
  output logic             susp
);
  l2_st_e           st_q, st_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      L_IDLE: begin
        if (req) begin
          if (delay == '0) begin
            st_d = L_HOLD;
          end else begin
            st_d  = L_WAIT;
            cnt_d = delay - DLY_W'(1);
          end
        end
      end
      L_WAIT: begin
        if (abort)              st_d  = L_IDLE;
        else if (cnt_q == '0)   st_d  = L_HOLD;
        else                    cnt_d = cnt_q - DLY_W'(1);
      end
      default: begin
        if (wake) st_d = L_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= L_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign susp = (st_q == L_HOLD);

  a_r9_abort_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == L_WAIT && abort) |=> !susp);
  a_r8_hold_until_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (susp && !wake) |=> susp);
endmodule

// File: rtl/throttle_ctl.sv
module throttle_ctl
  import thr_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DLY_W = 16,
  parameter int SCL_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [1:0]    rd_addr,
  input  logic          rd_io,
  input  logic [3:0]    rd_be,
  output logic [DW-1:0] rd_data,
  input  logic          irq,
  input  logic          smi,
  input  logic          dbg_int,
  input  logic          nmi,
  input  logic          sleep,
  input  logic          abort,
  output logic          suspend
);
  logic [1:0]       rsync;
  logic             rst_i_n;
  logic             en;
  logic [VAL_W-1:0] val;
  logic [DLY_W-1:0] delay;
  logic [SCL_W-1:0] scale;
  logic             pause, wake, l2_req;
  logic             thr_susp, l2_susp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= '0;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_i_n = rsync[1];

  assign pause  = irq || smi || dbg_int;
  assign wake   = pause || nmi;
  assign l2_req = rd_en && (rd_addr == A_LVL2) && rd_io && rd_be[0];

  thr_regs #(.DW(DW), .DLY_W(DLY_W), .SCL_W(SCL_W)) u_regs (
    .clk(clk), .rst_n(rst_i_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .nmi(nmi), .sleep(sleep),
    .rd_data(rd_data), .en(en), .val(val), .delay(delay), .scale(scale)
  );

  thr_seq #(.DLY_W(DLY_W), .SCL_W(SCL_W)) u_seq (
    .clk(clk), .rst_n(rst_i_n),
    .en(en), .val(val), .delay(delay), .scale(scale),
    .pause(pause), .susp(thr_susp)
  );

  lvl2_ctl #(.DLY_W(DLY_W)) u_lvl2 (
    .clk(clk), .rst_n(rst_i_n),
    .req(l2_req), .abort(abort), .wake(wake), .delay(delay),
    .susp(l2_susp)
  );

  assign suspend = thr_susp || l2_susp;

  a_r10_lvl2_reads_zero: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_en && rd_addr == A_LVL2) |-> (rd_data == '0));
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!en && !$past(l2_susp) && !l2_susp) |-> !suspend);
endmodule

// File: tb/sim_throttle_ctl.sv
module sim_throttle_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic        rd_io = 1'b0;
  logic [3:0]  rd_be = 4'hF;
  logic [31:0] rd_data;
  logic        irq = 1'b0, smi = 1'b0, dbg_int = 1'b0, nmi = 1'b0, sleep = 1'b0, abort = 1'b0;
  logic        suspend;

  int total = 0;
  int bad   = 0;

  throttle_ctl u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_io(rd_io), .rd_be(rd_be),
    .rd_data(rd_data),
    .irq(irq), .smi(smi), .dbg_int(dbg_int), .nmi(nmi), .sleep(sleep),
    .abort(abort), .suspend(suspend)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic io, input logic [3:0] be, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a; rd_io = io; rd_be = be;
    #1 d = rd_data;
    @(posedge clk);
    #1 begin rd_en = 1'b0; rd_io = 1'b0; rd_be = 4'hF; end
  endtask

  function automatic logic expf(int t, int d, int s, int r);
    int k;
    if (t < d + 1 || s == 0) return 1'b0;
    k = t - d - 1;
    return ((k % (s + r)) < s);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int s, r, teff;
    logic pprev, pnow;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 suspend", {31'b0, suspend}, 32'h0);
    rd(2'd0, 1'b0, 4'hF, d); check("R1 ctrl", d, 32'h0000000F);
    rd(2'd2, 1'b0, 4'hF, d); check("R1 delay", d, 32'h0);
    rd(2'd3, 1'b0, 4'hF, d); check("R1 scale", d, 32'h0);

    // R3 / R5 sweep over value, scale and delay
    for (int k = 1; k <= 2; k++) begin
      for (int di = 0; di < 2; di++) begin
        int dd;
        dd = (di == 0) ? 0 : 3;
        wr(2'd3, k);
        wr(2'd2, dd);
        for (int v = 0; v < 16; v++) begin
          s = (v == 0 || v == 15) ? 0 : (15 - v) * k;
          r = v * k;
          wr(2'd0, v);
          wr(2'd0, 32'h10 | v);
          for (int t = 0; t <= dd + 2 + 30 * k; t++) begin
            @(negedge clk);
            check((s == 0) ? "R5 no suspend" : "R3 duty", {31'b0, suspend}, {31'b0, expf(t, dd, s, r)});
          end
          wr(2'd0, 32'h0);
        end
      end
    end

    // R5 scale zero
    wr(2'd3, 0); wr(2'd2, 0);
    wr(2'd0, 3); wr(2'd0, 32'h13);
    for (int t = 0; t < 40; t++) begin
      @(negedge clk);
      check("R5 scale zero", {31'b0, suspend}, 32'h0);
    end
    wr(2'd0, 32'h0);

    // R2 layout and readback
    wr(2'd0, 32'h5A5A5A03);
    rd(2'd0, 1'b0, 4'hF, d); check("R2 readback", d, 32'h5A5A5A03);
    // R4 value locked while enabled
    wr(2'd0, 32'h00000013);
    wr(2'd0, 32'hC3C3C317);
    rd(2'd0, 1'b0, 4'hF, d); check("R4 value locked", d, 32'hC3C3C313);
    wr(2'd0, 32'h0);
    rd(2'd0, 1'b0, 4'hF, d); check("R2 disable keeps value", d, 32'h00000003);

    // R6 nmi and sleep clear enable
    wr(2'd3, 1); wr(2'd2, 0);
    wr(2'd0, 32'h01); wr(2'd0, 32'h11);
    repeat (3) @(negedge clk);
    check("R6 suspend before nmi", {31'b0, suspend}, 32'h1);
    nmi = 1'b1; @(negedge clk); nmi = 1'b0;
    check("R6 suspend after nmi", {31'b0, suspend}, 32'h0);
    rd(2'd0, 1'b0, 4'hF, d); check("R6 enable cleared by nmi", d, 32'h01);
    wr(2'd0, 32'h11);
    repeat (3) @(negedge clk);
    sleep = 1'b1; @(negedge clk); sleep = 1'b0;
    check("R6 suspend after sleep", {31'b0, suspend}, 32'h0);
    rd(2'd0, 1'b0, 4'hF, d); check("R6 enable cleared by sleep", d, 32'h01);

    // R7 pause by irq / smi / dbg_int
    wr(2'd2, 2);
    wr(2'd0, 32'h05); wr(2'd0, 32'h15);
    teff = 0; pprev = 1'b0;
    for (int t = 0; t < 70; t++) begin
      @(negedge clk);
      if (t > 0 && !pprev) teff++;
      pnow = irq | smi | dbg_int;
      check("R7 pause", {31'b0, suspend}, {31'b0, (pnow ? 1'b0 : expf(teff, 2, 10, 5))});
      irq     = (t >= 5 && t <= 7) || (t == 30);
      smi     = (t >= 14 && t <= 15);
      dbg_int = (t == 20) || (t == 41);
      pprev   = irq | smi | dbg_int;
    end
    irq = 1'b0; smi = 1'b0; dbg_int = 1'b0;
    wr(2'd0, 32'h0);
    repeat (2) @(negedge clk);

    // R8 level-2 suspend with delay 3
    wr(2'd2, 3);
    rd(2'd1, 1'b1, 4'h1, d); check("R8 lvl2 read zero", d, 32'h0);
    for (int t = 0; t < 14; t++) begin
      @(negedge clk);
      check("R8 lvl2 hold", {31'b0, suspend}, {31'b0, (t >= 3)});
    end
    irq = 1'b1; @(negedge clk); irq = 1'b0;
    check("R8 wake by irq", {31'b0, suspend}, 32'h0);

    // R8 delay zero, wake by nmi
    wr(2'd2, 0);
    rd(2'd1, 1'b1, 4'hF, d);
    @(negedge clk); check("R8 immediate suspend", {31'b0, suspend}, 32'h1);
    nmi = 1'b1; @(negedge clk); nmi = 1'b0;
    check("R8 wake by nmi", {31'b0, suspend}, 32'h0);

    // R9 abort during wait
    wr(2'd2, 5);
    rd(2'd1, 1'b1, 4'h1, d);
    for (int t = 0; t < 12; t++) begin
      @(negedge clk);
      check("R9 abort", {31'b0, suspend}, 32'h0);
      abort = (t == 2);
    end
    abort = 1'b0;

    // R10 no side effect paths
    wr(2'd2, 1);
    rd(2'd1, 1'b0, 4'hF, d); check("R10 register path zero", d, 32'h0);
    for (int t = 0; t < 6; t++) begin
      @(negedge clk); check("R10 register path", {31'b0, suspend}, 32'h0);
    end
    rd(2'd1, 1'b1, 4'hE, d); check("R10 no lane0 zero", d, 32'h0);
    for (int t = 0; t < 6; t++) begin
      @(negedge clk); check("R10 no lane0", {31'b0, suspend}, 32'h0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule